// File: doc/BRIEF.md
# Three-Voice Hard Sync Ring

This block keeps three 24-bit phase accumulators that run side by side and are tied together in a fixed ring for hard sync. On every clock each voice adds its own frequency word to its accumulator, unless its test bit holds it at zero. A voice whose sync bit is set is then restarted from zero whenever the voice that feeds it has just had its top bit go from low to high.

All three voices advance first. Every restart is then decided from the edges that this one shared update produced. Edges are not stored, so a sync bit that is set one cycle late misses that edge.

There is one ordering exception. Suppose a feeding voice is restarted by its own feeder in the very cycle its top bit rises. That rising edge is then not passed on to the next voice. A tone generator places this ring under its waveform shaping logic and reads the accumulators and edge strobes from it.

Top module: `hsn_sync_ring`

## Requirements
- R1: During and right after reset, every accumulator reads zero and every edge strobe reads low.
- R2: A voice whose test bit is high on a clock edge reads zero after that edge and shows no edge strobe. A voice held this way never restarts another voice.
- R3: A voice with its test bit low and no restart reads its old value plus its zero-extended 16-bit frequency word after each edge, modulo 2^24. Wrapping from the top down to zero raises no strobe.
- R4: The strobe of a voice (msb_rise_o bit i) is high for exactly the cycle after an edge in which bit 23 of its freshly added value is 1 and bit 23 of its previous value was 0. It is judged before any restart, so it stays high even if that voice is zeroed by its own sync in the same edge.
- R5: The sync sources are fixed: voice 0 is fed by voice 2, voice 1 by voice 0, and voice 2 by voice 1. Voice i's fields sit at bits [i*W +: W] of the packed buses.
- R6: A voice with its sync bit set reads zero after an edge in which its feeding voice's top bit rose. The restart wins over that edge's addition.
- R7: A voice is not restarted when its feeding voice's own sync bit is set and the feeding voice's own feeder also rose in the same edge. In that case the voice adds its frequency word as usual.
- R8: Restart is decided only in the edge where the feeder's top bit rises. Setting the sync bit in a later cycle does not zero the voice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_i | input | 48 | Three 16-bit frequency words, voice i at [16*i +: 16] |
| sync_i | input | 3 | Per-voice hard-sync enable |
| test_i | input | 3 | Per-voice hold-at-zero bit |
| acc_o | output | 72 | Three 24-bit accumulators, voice i at [24*i +: 24] |
| msb_rise_o | output | 3 | Per-voice top-bit rising strobe from the last update |

## Verification
The hardest case to reach is the exception in R7. It needs two neighbouring voices to cross bit 23 in the very same edge while the right sync bits are set, and free-running voices with unrelated frequencies almost never line up that way. The bench gets there by holding all voices at zero with their test bits. It then releases them together with the same frequency word, 0x8000, so that all three top bits rise on the 256th edge. Each voice's result can then be predicted exactly from its sync bits. The same launch-together method sets up the late-sync case in R8 and the silent wrap at edge 512.

// File: rtl/hsn_pkg.sv
package hsn_pkg;

   // Index of the voice that feeds voice idx in a ring of n voices.
   function automatic int unsigned ring_src(input int unsigned idx, input int unsigned n);
      return (idx + n - 1) % n;
   endfunction

   // Index of the voice that feeds the feeder of voice idx.
   function automatic int unsigned ring_src2(input int unsigned idx, input int unsigned n);
      return (idx + n - 2) % n;
   endfunction

endpackage

// File: rtl/hsn_phase_acc.sv
module hsn_phase_acc #(
   parameter int unsigned ACC_W  = 24,
   parameter int unsigned FREQ_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq,
   input  logic              test,
   input  logic              clear,
   output logic [ACC_W-1:0]  acc_q,
   output logic              rise_next,
   output logic              rise_q
);
   localparam int unsigned TOP = ACC_W - 1;
   localparam int unsigned PAD = ACC_W - FREQ_W;

   generate
      if (FREQ_W > ACC_W || FREQ_W == 0) begin : g_bad_width
         $error("hsn_phase_acc: FREQ_W must be in 1..ACC_W");
      end
   endgenerate

   logic [ACC_W-1:0] freq_ext;
   logic [ACC_W-1:0] sum;
   logic [ACC_W-1:0] next_val;

   generate
      if (PAD == 0) begin : g_nopad
         assign freq_ext = freq;
      end else begin : g_pad
         assign freq_ext = {{PAD{1'b0}}, freq};
      end
   endgenerate

   always_comb begin
      sum       = acc_q + freq_ext;
      next_val  = test ? '0 : sum;
      rise_next = next_val[TOP] & ~acc_q[TOP];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         rise_q <= 1'b0;
      end else begin
         acc_q  <= clear ? '0 : next_val;
         rise_q <= rise_next;
      end
   end

   p_test_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      test |=> (acc_q == '0 && !rise_q));

   p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!test && !clear) |=> acc_q == $past(acc_q + freq_ext));

   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> acc_q == '0);

   p_no_rise_from_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q[TOP] |=> !rise_q);

endmodule

// File: rtl/hsn_sync_resolve.sv
module hsn_sync_resolve
   import hsn_pkg::*;
#(
   parameter int unsigned N_VOICES = 3,
   parameter bit          GUARD_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_VOICES-1:0] rise,
   input  logic [N_VOICES-1:0] sync,
   output logic [N_VOICES-1:0] clear
);
   generate
      if (N_VOICES < 2) begin : g_bad_count
         $error("hsn_sync_resolve: ring needs at least two voices");
      end
   endgenerate

   for (genvar gi = 0; gi < N_VOICES; gi++) begin : g_voice
      localparam int unsigned SRC  = ring_src(gi, N_VOICES);
      localparam int unsigned SRC2 = ring_src2(gi, N_VOICES);
      logic blocked;
      if (GUARD_EN) begin : g_guard
         assign blocked = sync[SRC] & rise[SRC2];
      end else begin : g_noguard
         assign blocked = 1'b0;
      end
      assign clear[gi] = rise[SRC] & sync[gi] & ~blocked;

      p_need_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
         clear[gi] |-> (rise[SRC] && sync[gi]));
   end

endmodule

// File: rtl/hsn_sync_ring.sv
module hsn_sync_ring
   import hsn_pkg::*;
#(
   parameter int unsigned N_VOICES = 3,
   parameter int unsigned ACC_W    = 24,
   parameter int unsigned FREQ_W   = 16,
   parameter bit          GUARD_EN = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_VOICES*FREQ_W-1:0]   freq_i,
   input  logic [N_VOICES-1:0]          sync_i,
   input  logic [N_VOICES-1:0]          test_i,
   output logic [N_VOICES*ACC_W-1:0]    acc_o,
   output logic [N_VOICES-1:0]          msb_rise_o
);
   logic [N_VOICES-1:0] rise_next;
   logic [N_VOICES-1:0] clear;

   for (genvar gi = 0; gi < N_VOICES; gi++) begin : g_acc
      hsn_phase_acc #(.ACC_W(ACC_W), .FREQ_W(FREQ_W)) u_acc (
         .clk      (clk),
         .rst_n    (rst_n),
         .freq     (freq_i[gi*FREQ_W +: FREQ_W]),
         .test     (test_i[gi]),
         .clear    (clear[gi]),
         .acc_q    (acc_o[gi*ACC_W +: ACC_W]),
         .rise_next(rise_next[gi]),
         .rise_q   (msb_rise_o[gi])
      );
   end

   hsn_sync_resolve #(.N_VOICES(N_VOICES), .GUARD_EN(GUARD_EN)) u_res (
      .clk  (clk),
      .rst_n(rst_n),
      .rise (rise_next),
      .sync (sync_i),
      .clear(clear)
   );

   for (genvar gi = 0; gi < N_VOICES; gi++) begin : g_chk
      localparam int unsigned SRC  = ring_src(gi, N_VOICES);
      localparam int unsigned SRC2 = ring_src2(gi, N_VOICES);

      p_ring_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (msb_rise_o[SRC] && $past(sync_i[gi]) &&
          !(GUARD_EN && $past(sync_i[SRC]) && msb_rise_o[SRC2]))
         |-> acc_o[gi*ACC_W +: ACC_W] == '0);

      if (GUARD_EN) begin : g_guard_chk
         p_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (msb_rise_o[SRC] && msb_rise_o[SRC2] && $past(sync_i[SRC]) &&
             !$past(test_i[gi]) && !msb_rise_o[SRC] ^ msb_rise_o[SRC])
            |-> acc_o[gi*ACC_W +: ACC_W] ==
                $past(acc_o[gi*ACC_W +: ACC_W]) +
                ACC_W'($past(freq_i[gi*FREQ_W +: FREQ_W])));
      end
   end

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (acc_o == '0 && msb_rise_o == '0));

endmodule

// File: tb/sim_hsn_sync_ring.sv
module sim_hsn_sync_ring;
   localparam int NV = 3;
   localparam int AW = 24;
   localparam int FW = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NV*FW-1:0]  freq_i = '0;
   logic [NV-1:0]     sync_i = '0;
   logic [NV-1:0]     test_i = '0;
   logic [NV*AW-1:0]  acc_o;
   logic [NV-1:0]     msb_rise_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hsn_sync_ring u0 (
      .clk(clk), .rst_n(rst_n), .freq_i(freq_i), .sync_i(sync_i),
      .test_i(test_i), .acc_o(acc_o), .msb_rise_o(msb_rise_o)
   );

   // Vector: {f2,f1,f0}[69:22], sync[21:19], test[18:16], cycles[15:0]
   localparam int NVEC = 8;
   localparam logic [69:0] VEC [NVEC] = '{
      {16'hC123, 16'h7000, 16'hFFFF, 3'b111, 3'b000, 16'd300},
      {16'h4000, 16'h8000, 16'hFFFF, 3'b010, 3'b000, 16'd260},
      {16'h1234, 16'hF0F0, 16'h0F0F, 3'b000, 3'b000, 16'd200},
      {16'hFFFF, 16'hFFFF, 16'hFFFF, 3'b101, 3'b010, 16'd150},
      {16'h8000, 16'h8000, 16'h8000, 3'b000, 3'b111, 16'd3},
      {16'h8000, 16'h8000, 16'h8000, 3'b110, 3'b000, 16'd520},
      {16'hABCD, 16'h0001, 16'h7777, 3'b011, 3'b100, 16'd180},
      {16'hFFFF, 16'hE000, 16'hC000, 3'b111, 3'b000, 16'd400}
   };

   logic [AW-1:0] m_acc [NV];
   logic [NV-1:0] m_rise;

   task automatic model_tick();
      logic [AW-1:0] nx [NV];
      logic [NV-1:0] r;
      for (int i = 0; i < NV; i++) begin
         nx[i] = test_i[i] ? '0 : m_acc[i] + AW'(freq_i[i*FW +: FW]);
         r[i]  = nx[i][AW-1] & ~m_acc[i][AW-1];
      end
      for (int i = 0; i < NV; i++) begin
         int s;
         int ss;
         logic clr;
         s   = (i + NV - 1) % NV;
         ss  = (i + NV - 2) % NV;
         clr = r[s] & sync_i[i] & ~(sync_i[s] & r[ss]);
         m_acc[i] = clr ? '0 : nx[i];
      end
      m_rise = r;
   endtask

   task automatic check_acc(input int v, input logic [AW-1:0] exp, input string req);
      checks++;
      if (acc_o[v*AW +: AW] !== exp) begin
         failures++;
         $display("FAIL %s voice%0d acc actual=%h expected=%h", req, v,
                  acc_o[v*AW +: AW], exp);
      end
   endtask

   task automatic check_rise(input logic [NV-1:0] exp, input string req);
      checks++;
      if (msb_rise_o !== exp) begin
         failures++;
         $display("FAIL %s rise actual=%b expected=%b", req, msb_rise_o, exp);
      end
   endtask

   // one clock edge, inputs already driven, ends at negedge
   task automatic step();
      model_tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_model(input string req);
      for (int i = 0; i < NV; i++) check_acc(i, m_acc[i], req);
      check_rise(m_rise, req);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NV; i++) m_acc[i] = '0;
      m_rise = '0;
      rst_n = 1'b1;
   endtask

   task automatic launch(input logic [15:0] f, input logic [NV-1:0] sy);
      test_i = '1;
      freq_i = {NV{f}};
      sync_i = sy;
      step();
      test_i = '0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NV; i++) check_acc(i, '0, "R1");
      check_rise('0, "R1");
      rst_n = 1'b1;

      // table walk, model compared every cycle (R2 R3 R4 R5 R6 R7)
      for (int v = 0; v < NVEC; v++) begin
         freq_i = VEC[v][69:22];
         sync_i = VEC[v][21:19];
         test_i = VEC[v][18:16];
         for (int c = 0; c < int'(VEC[v][15:0]); c++) begin
            step();
            check_model("R3_R4_R6");
         end
      end

      // R7: all voices rise together on edge 256; voice1 fed by voice0 which is itself restarted
      launch(16'h8000, 3'b011);
      for (int c = 0; c < 255; c++) step();
      check_acc(0, 24'h7F8000, "R3");
      step();
      check_rise(3'b111, "R4");
      check_acc(0, 24'h000000, "R6");
      check_acc(1, 24'h800000, "R7");
      check_acc(2, 24'h800000, "R5");

      // R2: test bit mid-run forces zero, no strobe
      test_i = 3'b001;
      step();
      check_acc(0, 24'h000000, "R2");
      check_rise(3'b000, "R2");
      test_i = '0;

      // R8: late sync does not use the earlier edge; also R5 ordering
      launch(16'h8000, 3'b000);
      freq_i = {16'h0001, 16'h0001, 16'h8000};
      for (int c = 0; c < 256; c++) step();
      check_rise(3'b001, "R4");
      check_acc(1, 24'd256, "R8");
      sync_i = 3'b010;
      step();
      check_acc(1, 24'd257, "R8");
      check_rise(3'b000, "R8");

      // R3: wrap to zero at edge 512 gives no strobe
      launch(16'h8000, 3'b000);
      for (int c = 0; c < 512; c++) step();
      check_acc(0, 24'h000000, "R3");
      check_rise(3'b000, "R3");

      // R5: voice2 restarts from voice1 edge only
      launch(16'h8000, 3'b100);
      freq_i = {16'h0001, 16'h8000, 16'h0001};
      for (int c = 0; c < 256; c++) step();
      check_rise(3'b010, "R5");
      check_acc(2, 24'h000000, "R5");
      check_acc(0, 24'd256, "R5");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule